// File: doc/BRIEF.md
# Serial loss-of-signal monitor

This block watches a serial NRZ bit stream, one bit per cycle in which the bit-clock enable is high. It raises a loss-of-signal alarm when the line stops toggling for too long. It clears the alarm once the stream shows enough activity again. While the alarm is up, the receive data passed downstream is held at zero, so later logic sees a dead line and not noise.

An optical module's signal-detect output can also force the alarm. The module output enters on one pin. A second pin sets its polarity. The two are combined by XNOR, so a detector that is active high and one that is active low are both supported. An active-low enable turns the internal transition-based detection off, which leaves only the external path in effect.

Top module: `los_monitor`

## Requirements
- R1: With internal detection enabled, the internal loss state is set on the enabled bit that is the 129th (QUIET_LIMIT+1) consecutive sampled bit equal to its predecessor. `los` is high from the following cycle. A run of only 128 such bits does not set it.
- R2: Activity is measured in fixed windows of 128 (WIN_LEN) enabled bits. The first window starts with the first enabled bit after reset. The internal loss state clears at the close of a window that held 17 or more (more than CLR_THRESH) transitions. A window holding exactly 16 transitions leaves it set. Long bursts of transitions saturate the count and never wrap it.
- R3: `dout` equals `din` while `los` is low, and is 0 while `los` is high.
- R4: While `det_en_n` is 1, the internal loss state is cleared on the next clock edge and is never set.
- R5: The external loss indication is `ext_sd XNOR ext_pol`. When it is 1, `los` is 1 in the same cycle, whatever the internal state. `los` is the OR of the internal state and the external indication.
- R6: Reset puts the internal loss state in the lost condition, so `los` is 1 and `dout` is 0 after reset. The previous-bit register starts at 0 and the counters start at zero.
- R7: In a cycle with `bit_en` low, nothing is sampled or counted, and the internal loss state holds.
- R8: A transition is a sampled bit that differs from the previously sampled bit. The first enabled bit after reset is compared with 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_en | input | 1 | Bit-clock enable; `din` is sampled when high |
| din | input | 1 | Serial NRZ data in |
| det_en_n | input | 1 | Internal detection enable, active low |
| ext_sd | input | 1 | Signal-detect level from the optical module |
| ext_pol | input | 1 | Polarity select combined with `ext_sd` by XNOR |
| dout | output | 1 | Receive data, forced to 0 during loss |
| los | output | 1 | Combined loss-of-signal alarm |

## Verification
Two events can fall in the same cycle: the window close that clears the internal state, and an asserted external indication. The bench first lets the internal state enter loss. It then holds the external indication active while a window of alternating bits closes. The alarm must stay high through that close. It must drop in the first cycle after the external indication is released. A reference model in the bench, written from the requirements, predicts `los` and `dout` for every driven cycle. The exact-threshold cases of 128 and 129 quiet bits, and of 16 and 17 transitions per window, are checked directly.

// File: rtl/los_pkg.sv
package los_pkg;
   typedef enum logic {
      LOS_OK   = 1'b0,
      LOS_DOWN = 1'b1
   } los_state_t;
endpackage

// File: rtl/los_edge_det.sv
module los_edge_det (
   input  logic clk,
   input  logic rst,
   input  logic bit_en,
   input  logic din,
   output logic toggle
);
   logic prev_bit;

   always_ff @(posedge clk) begin
      if (rst)
         prev_bit <= 1'b0;
      else if (bit_en)
         prev_bit <= din;
   end

   assign toggle = bit_en & (din ^ prev_bit);
endmodule

// File: rtl/los_quiet_cnt.sv
module los_quiet_cnt #(
   parameter int QUIET_LIMIT = 128
) (
   input  logic clk,
   input  logic rst,
   input  logic bit_en,
   input  logic toggle,
   output logic quiet_hit
);
   localparam int RUN_MAX = QUIET_LIMIT + 1;
   localparam int RUN_W   = $clog2(RUN_MAX + 1);

   logic [RUN_W-1:0] run;

   assign quiet_hit = bit_en & ~toggle & (run >= RUN_W'(QUIET_LIMIT));

   always_ff @(posedge clk) begin
      if (rst)
         run <= '0;
      else if (bit_en) begin
         if (toggle)
            run <= '0;
         else if (run != RUN_W'(RUN_MAX))
            run <= run + RUN_W'(1);
      end
   end
endmodule

// File: rtl/los_window_cnt.sv
module los_window_cnt #(
   parameter int WIN_LEN    = 128,
   parameter int CLR_THRESH = 16
) (
   input  logic clk,
   input  logic rst,
   input  logic bit_en,
   input  logic toggle,
   output logic active_hit
);
   localparam int POS_W   = $clog2(WIN_LEN);
   localparam int CNT_MAX = CLR_THRESH + 1;
   localparam int CNT_W   = $clog2(CNT_MAX + 1);

   logic [POS_W-1:0] pos;
   logic             win_last;
   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] cnt_inc;

   generate
      if ((1 << POS_W) == WIN_LEN) begin : g_pow2
         assign win_last = &pos;
         always_ff @(posedge clk) begin
            if (rst)
               pos <= '0;
            else if (bit_en)
               pos <= pos + POS_W'(1);
         end
      end else begin : g_mod
         assign win_last = (pos == POS_W'(WIN_LEN - 1));
         always_ff @(posedge clk) begin
            if (rst)
               pos <= '0;
            else if (bit_en)
               pos <= win_last ? '0 : pos + POS_W'(1);
         end
      end
   endgenerate

   assign cnt_inc    = (toggle && (cnt != CNT_W'(CNT_MAX))) ? cnt + CNT_W'(1) : cnt;
   assign active_hit = bit_en & win_last & (cnt_inc > CNT_W'(CLR_THRESH));

   always_ff @(posedge clk) begin
      if (rst)
         cnt <= '0;
      else if (bit_en)
         cnt <= win_last ? '0 : cnt_inc;
   end
endmodule

// File: rtl/los_monitor.sv
module los_monitor
   import los_pkg::*;
#(
   parameter int QUIET_LIMIT = 128,
   parameter int WIN_LEN     = 128,
   parameter int CLR_THRESH  = 16
) (
   input  logic clk,
   input  logic rst,
   input  logic bit_en,
   input  logic din,
   input  logic det_en_n,
   input  logic ext_sd,
   input  logic ext_pol,
   output logic dout,
   output logic los
);
   generate
      if (QUIET_LIMIT < 1) begin : g_bad_quiet
         $error("QUIET_LIMIT must be at least 1");
      end
      if (WIN_LEN < 2) begin : g_bad_win
         $error("WIN_LEN must be at least 2");
      end
      if (CLR_THRESH < 0 || CLR_THRESH >= WIN_LEN) begin : g_bad_thr
         $error("CLR_THRESH must lie in 0..WIN_LEN-1");
      end
   endgenerate

   logic       toggle;
   logic       quiet_hit;
   logic       active_hit;
   logic       ext_loss;
   logic       int_down;
   los_state_t state;

   los_edge_det u_edge (
      .clk    (clk),
      .rst    (rst),
      .bit_en (bit_en),
      .din    (din),
      .toggle (toggle)
   );

   los_quiet_cnt #(.QUIET_LIMIT(QUIET_LIMIT)) u_quiet (
      .clk       (clk),
      .rst       (rst),
      .bit_en    (bit_en),
      .toggle    (toggle),
      .quiet_hit (quiet_hit)
   );

   los_window_cnt #(.WIN_LEN(WIN_LEN), .CLR_THRESH(CLR_THRESH)) u_win (
      .clk        (clk),
      .rst        (rst),
      .bit_en     (bit_en),
      .toggle     (toggle),
      .active_hit (active_hit)
   );

   always_ff @(posedge clk) begin
      if (rst)
         state <= LOS_DOWN;
      else if (det_en_n)
         state <= LOS_OK;
      else if (quiet_hit)
         state <= LOS_DOWN;
      else if (active_hit)
         state <= LOS_OK;
   end

   assign int_down = (state == LOS_DOWN);
   assign ext_loss = ~(ext_sd ^ ext_pol);
   assign los      = int_down | ext_loss;
   assign dout     = din & ~los;
endmodule

// File: rtl/los_monitor_chk.sv
module los_monitor_chk (
   input logic clk,
   input logic rst,
   input logic bit_en,
   input logic din,
   input logic det_en_n,
   input logic ext_sd,
   input logic ext_pol,
   input logic dout,
   input logic los,
   input logic int_down
);
   logic ext_on;
   assign ext_on = (ext_sd == ext_pol);

   assert_gate_low_R3: assert property (@(posedge clk) disable iff (rst)
      los |-> !dout);

   assert_gate_pass_R3: assert property (@(posedge clk) disable iff (rst)
      !los |-> (dout == din));

   assert_ext_force_R5: assert property (@(posedge clk) disable iff (rst)
      ext_on |-> los);

   assert_alarm_idle_R5: assert property (@(posedge clk) disable iff (rst)
      (!int_down && !ext_on) |-> !los);

   assert_disable_R4: assert property (@(posedge clk) disable iff (rst)
      det_en_n |=> !int_down);

   assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
      (!bit_en && !det_en_n) |=> $stable(int_down));

   assert_declare_R1: assert property (@(posedge clk) disable iff (rst)
      $rose(int_down) |-> ($past(bit_en) && !$past(det_en_n)));

   assert_clear_R2: assert property (@(posedge clk) disable iff (rst)
      ($fell(int_down) && !$past(det_en_n)) |-> $past(bit_en));
endmodule

bind los_monitor los_monitor_chk i_chk (
   .clk      (clk),
   .rst      (rst),
   .bit_en   (bit_en),
   .din      (din),
   .det_en_n (det_en_n),
   .ext_sd   (ext_sd),
   .ext_pol  (ext_pol),
   .dout     (dout),
   .los      (los),
   .int_down (int_down)
);

// File: tb/test_los_monitor.sv
`timescale 1ns/1ps
module test_los_monitor;
   localparam int QUIET = 128;
   localparam int WIN   = 128;
   localparam int THR   = 16;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic bit_en = 1'b0, din = 1'b0, det_en_n = 1'b0, ext_sd = 1'b1, ext_pol = 1'b0;
   logic dout, los;

   always #2 clk = ~clk;

   los_monitor i_los_monitor (
      .clk(clk), .rst(rst), .bit_en(bit_en), .din(din), .det_en_n(det_en_n),
      .ext_sd(ext_sd), .ext_pol(ext_pol), .dout(dout), .los(los)
   );

   typedef struct {
      logic  los;
      logic  dout;
      string tag;
   } exp_t;

   exp_t sb[$];
   int   total = 0;
   int   bad   = 0;
   bit   ended = 0;

   // reference model state, built from the requirements
   logic m_prev = 1'b0;
   int   m_run = 0, m_pos = 0, m_cnt = 0;
   logic m_down = 1'b1;
   logic g_dis = 1'b0, g_sd = 1'b1, g_pol = 1'b0;

   task automatic report;
      if (!ended) begin
         ended = 1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   endtask

   task automatic drive(input logic en, input logic d, input string tag);
      exp_t e;
      bit t, qh, clr, last;
      int cn;
      @(negedge clk);
      bit_en = en; din = d; det_en_n = g_dis; ext_sd = g_sd; ext_pol = g_pol;
      qh = 0; clr = 0;
      if (en) begin
         t = (d != m_prev);                        // R8
         m_prev = d;
         qh = !t && (m_run >= QUIET);              // R1
         m_run = t ? 0 : ((m_run < QUIET + 1) ? m_run + 1 : m_run);
         cn = m_cnt + (t ? 1 : 0);
         if (cn > THR + 1) cn = THR + 1;
         last = (m_pos == WIN - 1);
         clr = last && (cn > THR);                 // R2
         m_cnt = last ? 0 : cn;
         m_pos = last ? 0 : m_pos + 1;
      end
      if (g_dis) m_down = 1'b0;
      else if (qh) m_down = 1'b1;
      else if (clr) m_down = 1'b0;
      e.los  = m_down | (g_sd == g_pol);
      e.dout = d & !e.los;
      e.tag  = tag;
      sb.push_back(e);
   endtask

   task automatic expect_los(input logic e, input string tag);
      @(posedge clk); #1;
      total++;
      if (los !== e) begin
         bad++;
         $display("FAIL %s: los=%b expected %b", tag, los, e);
      end
   endtask

   task automatic quiet(input int n, input string tag);
      for (int i = 0; i < n; i++) drive(1'b1, m_prev, tag);
   endtask

   task automatic alt(input int n, input string tag);
      for (int i = 0; i < n; i++) drive(1'b1, !m_prev, tag);
   endtask

   task automatic align(input string tag);
      while (m_pos != 0) drive(1'b1, m_prev, tag);
   endtask

   // monitor: compares one expected item per driven cycle
   initial begin
      exp_t e;
      forever begin
         @(posedge clk); #1;
         if (sb.size() > 0) begin
            e = sb.pop_front();
            total++;
            if (los !== e.los || dout !== e.dout) begin
               bad++;
               $display("FAIL %s: los=%b dout=%b expected los=%b dout=%b",
                        e.tag, los, dout, e.los, e.dout);
            end
         end
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      bad++;
      $display("FAIL watchdog: run did not end, expected completion");
      report();
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk) rst = 1'b0;
      // R6: reset leaves the alarm up and data gated
      @(posedge clk); #1;
      total++;
      if (los !== 1'b1 || dout !== 1'b0) begin
         bad++;
         $display("FAIL R6: los=%b dout=%b expected los=1 dout=0", los, dout);
      end

      // R8 / R2: alternating window from reset clears loss; counter saturates
      alt(WIN - 1, "R2 alternating");
      drive(1'b1, !m_prev, "R2 window close");
      expect_los(1'b0, "R2 clear after busy window");

      // R3: data passes while clear
      for (int i = 0; i < 40; i++) drive(1'b1, ((i * 5) % 7) > 2, "R3 pass data");

      // R1: 128 quiet bits keep, 129th declares
      quiet(QUIET, "R1 quiet run");
      expect_los(1'b0, "R1 128 quiet bits");
      drive(1'b1, m_prev, "R1 129th bit");
      expect_los(1'b1, "R1 129 quiet bits");
      for (int i = 0; i < 20; i++) drive(1'b1, i[1], "R3 gated data");

      // R2 boundary: 16 transitions not enough, 17 clears
      align("R2 align");
      alt(THR, "R2 sixteen");
      quiet(WIN - THR - 1, "R2 sixteen rest");
      drive(1'b1, m_prev, "R2 sixteen close");
      expect_los(1'b1, "R2 exactly 16 transitions");
      alt(THR + 1, "R2 seventeen");
      quiet(WIN - THR - 2, "R2 seventeen rest");
      drive(1'b1, m_prev, "R2 seventeen close");
      expect_los(1'b0, "R2 17 transitions");

      // R7: held state with enable low, in loss and in clear
      for (int i = 0; i < 300; i++) drive(1'b0, i[0], "R7 idle while clear");
      quiet(QUIET + 1, "R1 enter loss");
      for (int i = 0; i < 300; i++) drive(1'b0, i[0], "R7 idle while lost");
      expect_los(1'b1, "R7 enable low holds loss");

      // R4: disabling clears and prevents loss
      g_dis = 1'b1;
      drive(1'b1, m_prev, "R4 disable");
      expect_los(1'b0, "R4 disable clears");
      quiet(300, "R4 quiet while disabled");
      g_dis = 1'b0;
      alt(30, "R4 re-enable");

      // R5: XNOR polarity combinations
      g_sd = 1'b0; g_pol = 1'b0; alt(4, "R5 sd0 pol0");
      g_sd = 1'b1; g_pol = 1'b0; alt(4, "R5 sd1 pol0");
      g_sd = 1'b1; g_pol = 1'b1; alt(4, "R5 sd1 pol1");
      g_sd = 1'b0; g_pol = 1'b1; alt(4, "R5 sd0 pol1");

      // R5 with R2 in the same cycle: window clear under external loss
      quiet(QUIET + 1, "R1 enter loss again");
      align("R5 align");
      g_sd = 1'b1; g_pol = 1'b1;
      alt(WIN - 1, "R5 busy under ext");
      drive(1'b1, !m_prev, "R5 close under ext");
      expect_los(1'b1, "R5 ext holds alarm at clear");
      g_sd = 1'b0;
      drive(1'b1, !m_prev, "R5 ext released");
      expect_los(1'b0, "R5 alarm drops after release");
      alt(10, "R3 pass after release");

      while (sb.size() > 0) @(posedge clk);
      repeat (3) @(posedge clk);
      report();
   end
endmodule